// File: doc/BRIEF.md
# Serial Stripe Pattern Monitor

This block watches a serial bit stream, one bit per clock, least significant bit first, and tells after every bit whether everything received since the last start strobe is still the beginning of an evenly striped word. An evenly striped word opens with a run of w ones at bit 0. After that it alternates runs of exactly w zeros and w ones. The width w is not configured. The block learns it from the length of the opening run of ones, and w is fixed when the first zero arrives.

A start strobe is raised together with bit 0 of each vector. It discards all history, so vectors may follow each other with no idle cycle. Once the stream breaks the pattern, the verdict stays low until the next strobe. The verdict comes from a flop that is updated on the same rising edge that takes in the bit.

Top module: `stripe_prefix_mon`

## Requirements
- R1: After reset `prefix_ok_o` is 0, and it stays 0 while bits arrive with `start_i` low before any start strobe.
- R2: When the bit taken in with `start_i` is 0, `prefix_ok_o` is 0 after that edge and stays 0 for the rest of that vector.
- R3: While every bit since the start strobe has been 1, `prefix_ok_o` is 1.
- R4: The first 0 fixes the width w as the number of ones before it. After that, each run must hold exactly w bits: w zeros, then w ones, and so on. A run that ends early or goes on too long drops `prefix_ok_o` at the first bit that breaks the pattern.
- R5: Once `prefix_ok_o` is 0, it stays 0 for every later bit until a start strobe arrives.
- R6: A start strobe clears all history, including an earlier failure, and judges the bit that arrives with it as bit 0 of a new vector. Back-to-back vectors need no idle cycle.
- R7: `prefix_ok_o` changes only on the rising edge that takes in the bit it judges. Before that edge it still shows the verdict for the previous bit.
- R8: Widths up to the full vector length of 32 are handled. A vector of 32 ones keeps `prefix_ok_o` at 1 for all 32 bits, and so does 31 ones followed by a single 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; bits are taken in on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | High together with bit 0 of each vector |
| bit_i | input | 1 | Serial data bit, least significant first |
| prefix_ok_o | output | 1 | 1 while the bits received so far form a valid striped prefix |

## Verification
Some properties are checked on every clock, in any stream. These are: a failure is sticky while no strobe arrives; a strobe with a 0 gives a low verdict and a strobe with a 1 gives a high one; the run counter never passes the learned width; the learned width is never zero; the expected bit flips whenever a run completes; and the learning counter counts up without wrapping. Other behaviour depends on whole sequences, so only the bench's scenarios can show it. This covers the exact bit position where a run that is too short or too long is caught, full 32-bit widths, the silence before the first strobe, and the timing of the verdict relative to the edge.

// File: rtl/stripe_mon_pkg.sv
package stripe_mon_pkg;

  typedef enum logic {
    PH_LEARN = 1'b0,
    PH_CHECK = 1'b1
  } phase_e;

  // Bit expected in the next position: the current run value, inverted
  // when the run has just reached its full width.
  function automatic logic f_expected(input logic cur_val, input logic run_full);
    return run_full ? ~cur_val : cur_val;
  endfunction

endpackage

// File: rtl/stripe_tracker.sv
module stripe_tracker
  import stripe_mon_pkg::*;
#(
  parameter int unsigned CW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          bit_i,
  input  logic          hold_i,
  output logic          miss_o,
  output logic          lock_o,
  output logic          flip_o,
  output phase_e        phase_o,
  output logic [CW-1:0] width_o,
  output logic [CW-1:0] run_o
);

  localparam logic [CW-1:0] RUN_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] RUN_ONE = CW'(1);

  function automatic logic [CW-1:0] f_sat_inc(input logic [CW-1:0] v);
    return (v == RUN_MAX) ? v : v + RUN_ONE;
  endfunction

  phase_e        phase_q, phase_d, phase_eff;
  logic [CW-1:0] width_q, width_d;
  logic [CW-1:0] run_q, run_d, run_eff;
  logic          exp_q, exp_d, exp_now;

  always_comb begin
    phase_eff = start_i ? PH_LEARN : phase_q;
    run_eff   = start_i ? '0 : run_q;
    phase_d   = phase_eff;
    width_d   = width_q;
    run_d     = run_eff;
    exp_d     = exp_q;
    exp_now   = exp_q;
    miss_o    = 1'b0;
    lock_o    = 1'b0;
    flip_o    = 1'b0;
    if (phase_eff == PH_LEARN) begin
      if (bit_i) begin
        run_d = f_sat_inc(run_eff);
      end else if (run_eff == '0) begin
        miss_o = 1'b1;
      end else begin
        lock_o  = 1'b1;
        width_d = run_eff;
        phase_d = PH_CHECK;
        exp_d   = 1'b0;
        run_d   = RUN_ONE;
      end
    end else begin
      flip_o  = (run_eff == width_q);
      exp_now = f_expected(exp_q, flip_o);
      miss_o  = (bit_i != exp_now);
      exp_d   = exp_now;
      run_d   = flip_o ? RUN_ONE : run_eff + RUN_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_LEARN;
      width_q <= '0;
      run_q   <= '0;
      exp_q   <= 1'b0;
    end else if (!hold_i) begin
      phase_q <= phase_d;
      width_q <= width_d;
      run_q   <= run_d;
      exp_q   <= exp_d;
    end
  end

  assign phase_o = phase_q;
  assign width_o = width_q;
  assign run_o   = run_q;

  // R4: in the checking phase the run length stays within 1..width
  p_run_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_CHECK) |-> (run_q >= RUN_ONE && run_q <= width_q));

  // R4: locking the width leaves a non-zero width and the checking phase
  p_lock_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_o && !hold_i) |=> (width_q != '0 && phase_q == PH_CHECK));

  // R4: a completed run flips the expected bit
  p_flip_toggle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (flip_o && !hold_i && !start_i && phase_q == PH_CHECK) |=> (exp_q != $past(exp_q)));

  // R8: the learning counter advances by one without wrapping
  p_learn_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_i && !start_i && phase_q == PH_LEARN && bit_i && run_q != RUN_MAX)
      |=> (run_q == $past(run_q) + RUN_ONE));

endmodule

// File: rtl/stripe_verdict.sv
module stripe_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic miss_i,
  output logic fail_o,
  output logic ok_o
);

  logic fail_q, fail_d;

  always_comb begin
    fail_d = start_i ? miss_i : (fail_q | miss_i);
  end

  // Reset leaves the monitor idle: failed until the first start strobe.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fail_q <= 1'b1;
    else        fail_q <= fail_d;
  end

  assign fail_o = fail_q;
  assign ok_o   = ~fail_q;

  // R5: failure persists while no strobe arrives
  p_sticky_fail_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_q && !start_i) |=> fail_q);

  // R6: a strobe whose bit matches gives a passing verdict
  p_restart_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !miss_i) |=> ok_o);

endmodule

// File: rtl/stripe_prefix_mon.sv
module stripe_prefix_mon
  import stripe_mon_pkg::*;
#(
  parameter int unsigned MAX_LEN = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic bit_i,
  output logic prefix_ok_o
);

  localparam int unsigned CW = $clog2(MAX_LEN + 1);

  logic          miss_evt;
  logic          lock_evt;
  logic          flip_evt;
  logic          fail_st;
  logic          hold_trk;
  phase_e        phase_st;
  logic [CW-1:0] width_st;
  logic [CW-1:0] run_st;

  assign hold_trk = fail_st & ~start_i;

  stripe_tracker #(.CW(CW)) u_tracker (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .bit_i   (bit_i),
    .hold_i  (hold_trk),
    .miss_o  (miss_evt),
    .lock_o  (lock_evt),
    .flip_o  (flip_evt),
    .phase_o (phase_st),
    .width_o (width_st),
    .run_o   (run_st)
  );

  stripe_verdict u_verdict (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start_i),
    .miss_i  (miss_evt),
    .fail_o  (fail_st),
    .ok_o    (prefix_ok_o)
  );

  // R2: a strobe with a 0 bit fails at once
  p_first_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !bit_i) |=> !prefix_ok_o);

  // R3: a strobe with a 1 bit passes
  p_first_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && bit_i) |=> prefix_ok_o);

  // R5: a low verdict stays low without a strobe
  p_hold_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!prefix_ok_o && !start_i) |=> !prefix_ok_o);

endmodule

// File: tb/stripe_prefix_mon_tb_top.sv
module stripe_prefix_mon_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;

  // {vector, number of leading bits that form a valid prefix}
  localparam logic [37:0] VEC_TBL [NVEC] = '{
    {32'h5555_5555, 6'd32},
    {32'h3333_3333, 6'd32},
    {32'hFFFF_FFFF, 6'd32},
    {32'h0000_0000, 6'd0},
    {32'h0F0F_0F0F, 6'd32},
    {32'h0000_FFFF, 6'd32},
    {32'h0000_0007, 6'd6},
    {32'h0000_000B, 6'd3},
    {32'h7FFF_FFFF, 6'd32},
    {32'h5555_5455, 6'd8},
    {32'h0000_0001, 6'd2},
    {32'h3333_3373, 6'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic bit_i = 1'b0;
  logic prefix_ok_o;

  int n_checks = 0;
  int n_fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stripe_prefix_mon dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .bit_i       (bit_i),
    .prefix_ok_o (prefix_ok_o)
  );

  task automatic check(input string req, input logic exp_v, input string what);
    n_checks++;
    if (prefix_ok_o !== exp_v) begin
      n_fails++;
      $display("FAIL %s %s: got %b expected %b", req, what, prefix_ok_o, exp_v);
    end
  endtask

  // drive at a falling edge; result visible at the next falling edge
  task automatic send_bit(input logic s, input logic b);
    start_i = s;
    bit_i   = b;
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: got hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    string tag;
    @(negedge clk);
    @(negedge clk);
    check("R1", 1'b0, "in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 1'b0, "after reset");
    for (int i = 0; i < 4; i++) begin
      send_bit(1'b0, 1'b1);
      check("R1", 1'b0, "ones before any strobe");
    end

    // table walk, vectors back to back
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] vec;
      int upto;
      vec  = VEC_TBL[v][37:6];
      upto = int'(VEC_TBL[v][5:0]);
      for (int pos = 0; pos < 32; pos++) begin
        send_bit(pos == 0, vec[pos]);
        if (vec == 32'hFFFF_FFFF || vec == 32'h7FFF_FFFF) tag = "R8";
        else if (upto == 0) tag = "R2";
        else if (pos >= upto) tag = "R5";
        else if (pos > 0 && vec[pos] != vec[0]) tag = "R4";
        else tag = "R3";
        check(tag, logic'(pos < upto), $sformatf("vec %h pos %0d", vec, pos));
      end
    end

    // R6: fail, then restart mid-stream without idle
    send_bit(1'b1, 1'b0);
    check("R2", 1'b0, "zero at strobe");
    send_bit(1'b0, 1'b1);
    check("R5", 1'b0, "one after failed start");
    // R7: verdict unchanged before the edge, updated after it
    start_i = 1'b1;
    bit_i   = 1'b1;
    #(CLK_PERIOD/2 - 1);
    check("R7", 1'b0, "before edge");
    @(negedge clk);
    check("R6", 1'b1, "restart clears failure");
    send_bit(1'b0, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R4", 1'b1, "width 2 lock");
    send_bit(1'b0, 1'b0);
    check("R4", 1'b1, "second zero of width 2");
    send_bit(1'b0, 1'b0);
    check("R4", 1'b0, "zero run too long");
    // R6: restart in the middle of a good vector
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R6", 1'b1, "new width 1");
    send_bit(1'b1, 1'b0);
    check("R6", 1'b0, "strobe with zero mid-vector");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule